// File: doc/BRIEF.md
# Two-Phase Clock Stabilization Reset Sequencer

This block keeps the rest of the chip in reset after power-on until the chosen oscillator has had time to settle. The wait is split into two phases of equal length in ticks. The first phase always counts ticks of source 0, the internal default oscillator. When it completes, the block captures a configuration word from non-volatile storage. The low bits of that word pick which clock source is active for the second phase. The second phase then counts ticks of the picked source, so the total delay depends on that oscillator's rate. At the end the block raises a sticky reset-release output.

The block runs on one free-running reference clock. Each candidate oscillator appears only as a single-cycle tick enable on that clock. A prescaler divides the active source's ticks by `PRESCALE`, and a phase counter counts `PHASE_LEN` prescaled periods. With the default values (1024 and 128), a 4 MHz default source gives 32 ms per phase, and a 16 MHz source gives an 8 ms second phase.

Top module: `clk_stab_seq`

## Requirements
- R1: While `porIn` is high, `rstRelease` and `optValid` are 0, `srcSel` is 0 and `optLatched` is 0. When `porIn` rises, these values take effect at once, without waiting for a clock edge.
- R2: After `porIn` falls, phase 1 counts `PHASE_LEN*PRESCALE` ticks of `srcTick[0]`, sampled on rising clock edges. Ticks on the other sources are ignored during phase 1.
- R3: The option is captured on the first clock edge after the edge that carries the last phase-1 tick. From then on, `optLatched` equals `optWord` as sampled on that edge, and `srcSel` equals bits [SEL_W-1:0] of that word.
- R4: `optValid` is high for exactly one cycle per sequence, in the cycle after the capture edge.
- R5: Both counters clear on the capture edge, and a tick present on that edge is not counted. Phase 2 then counts `PHASE_LEN*PRESCALE` ticks of `srcTick[srcSel]` on the edges that follow, and no partial prescaler count carries over from phase 1.
- R6: `rstRelease` rises on the first clock edge after the edge that carries the last phase-2 tick, and it stays high until `porIn` is asserted.
- R7: A change of `optWord` after the capture edge has no effect on `optLatched`, on `srcSel`, or on when `rstRelease` rises.
- R8: Asserting `porIn` at any point aborts the sequence, and the next release of `porIn` starts a full new sequence from phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| srcTick | input | NUM_SRC | One single-cycle tick enable per candidate clock source; bit 0 is the default source |
| optWord | input | OPT_W | Configuration word read from non-volatile storage |
| optLatched | output | OPT_W | Configuration word captured at the end of phase 1 |
| srcSel | output | SEL_W | Index of the active clock source |
| optValid | output | 1 | One-cycle strobe that marks the capture of the option |
| rstRelease | output | 1 | Reset release, registered and sticky |

## Verification
The assertions assume that `porIn` is the only way back to the start. They also assume that the tick of each source is a level sampled on rising clock edges, so a tick that stays high for several cycles counts once per edge. The bench drives each tick from a bench cycle counter, and each source has a fixed period from one to six cycles. Because the tick edges are known exactly, the expected capture cycle and release cycle can be worked out ahead of time. The bench changes `optWord` only while `porIn` is high or after the capture has been observed, except where it tests R7 on purpose. It asserts `porIn` only on a falling clock edge.

// File: rtl/clk_stab_pkg.sv
`timescale 1ns/1ps
package clk_stab_pkg;

  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_DONE   = 2'd2
  } phase_e;

  // Strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic cntEn;       // advance on the active source's tick
    logic cntClr;      // clear prescaler and phase counter
    logic latchOpt;    // capture the option word and switch source
    logic setRelease;  // raise reset release
  } seqCtrl_t;

endpackage

// File: rtl/clk_stab_ctrl.sv
`timescale 1ns/1ps
module clk_stab_ctrl
  import clk_stab_pkg::*;
(
  input  logic     clk,
  input  logic     porIn,
  input  logic     phaseDone,
  output seqCtrl_t ctrl
);

  phase_e state, stateNext;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) state <= PH_FIRST;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      PH_FIRST: begin
        ctrl.cntEn = !phaseDone;
        if (phaseDone) begin
          ctrl.latchOpt = 1'b1;
          ctrl.cntClr   = 1'b1;
          stateNext     = PH_SECOND;
        end
      end
      PH_SECOND: begin
        ctrl.cntEn = !phaseDone;
        if (phaseDone) begin
          ctrl.setRelease = 1'b1;
          stateNext       = PH_DONE;
        end
      end
      default: begin
        stateNext = PH_DONE;
      end
    endcase
  end

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (porIn)
    state == PH_DONE |=> state == PH_DONE);

  // R4
  latch_once_chk: assert property (@(posedge clk) disable iff (porIn)
    ctrl.latchOpt |=> state == PH_SECOND);

endmodule

// File: rtl/clk_stab_dp.sv
`timescale 1ns/1ps
module clk_stab_dp
  import clk_stab_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int OPT_W     = 8,
  parameter int PRESCALE  = 1024,
  parameter int PHASE_LEN = 128,
  localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1,
  localparam int PH_W     = $clog2(PHASE_LEN + 1)
) (
  input  logic               clk,
  input  logic               porIn,
  input  seqCtrl_t           ctrl,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [OPT_W-1:0]   optWord,
  output logic               phaseDone,
  output logic [OPT_W-1:0]   optLatched,
  output logic [SEL_W-1:0]   srcSel,
  output logic               optValid,
  output logic               rstRelease
);

  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESCALE - 1);
  localparam logic [PH_W-1:0]  PH_END  = PH_W'(PHASE_LEN);

  logic [PRE_W-1:0] preCnt;
  logic [PH_W-1:0]  phCnt;
  logic             tickActive;

  assign tickActive = srcTick[srcSel];
  assign phaseDone  = (phCnt == PH_END);

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      preCnt     <= '0;
      phCnt      <= '0;
      optLatched <= '0;
      srcSel     <= '0;
      optValid   <= 1'b0;
      rstRelease <= 1'b0;
    end else begin
      optValid <= ctrl.latchOpt;
      if (ctrl.latchOpt) begin
        optLatched <= optWord;
        srcSel     <= optWord[SEL_W-1:0];
      end
      if (ctrl.setRelease) rstRelease <= 1'b1;
      if (ctrl.cntClr) begin
        preCnt <= '0;
        phCnt  <= '0;
      end else if (ctrl.cntEn && tickActive) begin
        if (preCnt == PRE_MAX) begin
          preCnt <= '0;
          phCnt  <= phCnt + 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  // R5
  prescale_range_chk: assert property (@(posedge clk) disable iff (porIn)
    preCnt <= PRE_MAX);

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (porIn)
    phCnt <= PH_END);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (porIn)
    ctrl.cntClr |=> (preCnt == '0 && phCnt == '0));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (porIn)
    optValid |=> !optValid);

  // R6
  release_sticky_chk: assert property (@(posedge clk) disable iff (porIn)
    rstRelease |=> rstRelease);

  // R6
  release_follow_chk: assert property (@(posedge clk) disable iff (porIn)
    ctrl.setRelease |=> rstRelease);

  // R7
  opt_hold_chk: assert property (@(posedge clk) disable iff (porIn)
    !ctrl.latchOpt |=> ($stable(optLatched) && $stable(srcSel)));

endmodule

// File: rtl/clk_stab_seq.sv
`timescale 1ns/1ps
module clk_stab_seq
  import clk_stab_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int OPT_W     = 8,
  parameter int PRESCALE  = 1024,
  parameter int PHASE_LEN = 128,
  localparam int SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [OPT_W-1:0]   optWord,
  output logic [OPT_W-1:0]   optLatched,
  output logic [SEL_W-1:0]   srcSel,
  output logic               optValid,
  output logic               rstRelease
);

  seqCtrl_t ctrl;
  logic     phaseDone;

  clk_stab_ctrl u_ctrl (
    .clk       (clk),
    .porIn     (porIn),
    .phaseDone (phaseDone),
    .ctrl      (ctrl)
  );

  clk_stab_dp #(
    .NUM_SRC   (NUM_SRC),
    .OPT_W     (OPT_W),
    .PRESCALE  (PRESCALE),
    .PHASE_LEN (PHASE_LEN)
  ) u_dp (
    .clk        (clk),
    .porIn      (porIn),
    .ctrl       (ctrl),
    .srcTick    (srcTick),
    .optWord    (optWord),
    .phaseDone  (phaseDone),
    .optLatched (optLatched),
    .srcSel     (srcSel),
    .optValid   (optValid),
    .rstRelease (rstRelease)
  );

endmodule

// File: tb/clk_stab_seq_bench.sv
`timescale 1ns/1ps
module clk_stab_seq_bench;

  localparam int NUM_SRC   = 4;
  localparam int OPT_W     = 8;
  localparam int PRESCALE  = 4;
  localparam int PHASE_LEN = 8;
  localparam int TOTAL     = PRESCALE * PHASE_LEN;

  typedef struct {
    int       kind;  // 0 = option capture, 1 = release
    int       t;     // expected bench cycle counter value
    logic [7:0] opt;
  } expItem_t;

  logic             clk = 1'b0;
  logic             porIn = 1'b1;
  logic [3:0]       srcTick;
  logic [7:0]       optWord = 8'h00;
  logic [7:0]       optLatched;
  logic [1:0]       srcSel;
  logic             optValid;
  logic             rstRelease;

  int nChecks = 0;
  int nFails  = 0;
  int tcnt;
  bit seenValid = 1'b0;
  bit prevRel = 1'b0;
  bit prevValid = 1'b0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  clk_stab_seq #(
    .NUM_SRC(NUM_SRC), .OPT_W(OPT_W), .PRESCALE(PRESCALE), .PHASE_LEN(PHASE_LEN)
  ) u_clk_stab_seq (
    .clk(clk), .porIn(porIn), .srcTick(srcTick), .optWord(optWord),
    .optLatched(optLatched), .srcSel(srcSel), .optValid(optValid),
    .rstRelease(rstRelease)
  );

  function automatic int perOf(int i);
    case (i)
      0: return 6;
      1: return 3;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  // edge counter since porIn release; tick i seen on edge k iff k%per==per-1
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) tcnt <= 0;
    else       tcnt <= tcnt + 1;
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      srcTick[i] = ((tcnt % perOf(i)) == perOf(i) - 1);
  end

  function automatic int nthEdge(int per, int start, int n);
    int seen = 0;
    for (int k = start; k < start + n * per + per; k++) begin
      if ((k % per) == per - 1) begin
        seen++;
        if (seen == n) return k;
      end
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pop expected events as the design produces them
  always @(negedge clk) begin
    if (!porIn) begin
      if (optValid) begin
        chk(!prevValid, "R4", "optValid longer than one cycle", 1, 0);
        if (!prevValid) begin
          if (expQ.size() == 0 || expQ[0].kind != 0) begin
            chk(1'b0, "R4", "unexpected optValid pulse", 1, 0);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            chk(tcnt == it.t, "R2", "capture cycle", tcnt, it.t);
            chk(optLatched == it.opt, "R3", "optLatched", optLatched, it.opt);
            chk(srcSel == it.opt[1:0], "R3", "srcSel", srcSel, it.opt[1:0]);
            seenValid = 1'b1;
          end
        end
      end
      if (rstRelease && !prevRel) begin
        if (expQ.size() == 0 || expQ[0].kind != 1) begin
          chk(1'b0, "R6", "unexpected release", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(tcnt == it.t, "R5", "release cycle", tcnt, it.t);
          chk(optLatched == it.opt, "R7", "optLatched at release", optLatched, it.opt);
        end
      end
      prevRel   = rstRelease;
      prevValid = optValid;
    end else begin
      prevRel   = 1'b0;
      prevValid = 1'b0;
    end
  end

  task automatic checkResetState(string tag);
    chk(rstRelease == 1'b0, "R1", {tag, " rstRelease in reset"}, rstRelease, 0);
    chk(optValid == 1'b0, "R1", {tag, " optValid in reset"}, optValid, 0);
    chk(srcSel == 2'd0, "R1", {tag, " srcSel in reset"}, srcSel, 0);
    chk(optLatched == 8'h00, "R1", {tag, " optLatched in reset"}, optLatched, 0);
  endtask

  // driver: push expected events, run one sequence
  task automatic runSeq(logic [7:0] opt, bit abortIt, bit changeOpt);
    int e1, e2;
    expItem_t a, b;
    e1 = nthEdge(perOf(0), 0, TOTAL);
    e2 = nthEdge(perOf(int'(opt[1:0])), e1 + 2, TOTAL);
    a.kind = 0; a.t = e1 + 2; a.opt = opt;
    expQ.push_back(a);
    if (!abortIt) begin
      b.kind = 1; b.t = e2 + 2; b.opt = opt;
      expQ.push_back(b);
    end
    optWord = opt;
    seenValid = 1'b0;
    @(negedge clk);
    porIn = 1'b0;
    for (int c = 0; c < 1000 && !seenValid; c++) @(negedge clk);
    chk(seenValid, "R2", "option capture seen", seenValid, 1);
    if (changeOpt) optWord = ~opt;  // R7 stimulus
    if (abortIt) begin
      repeat (5) @(negedge clk);
      porIn = 1'b1;
      #1;
      chk(rstRelease == 1'b0, "R8", "release after abort", rstRelease, 0);
      chk(srcSel == 2'd0, "R8", "srcSel after abort", srcSel, 0);
      @(negedge clk);
      chk(expQ.size() == 0, "R8", "pending events after abort", expQ.size(), 0);
      return;
    end
    for (int c = 0; c < 1000 && !rstRelease; c++) @(negedge clk);
    chk(rstRelease, "R6", "release reached", rstRelease, 1);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk(rstRelease, "R6", "release held", rstRelease, 1);
    end
    chk(optLatched == opt, "R7", "option held after release", optLatched, opt);
    chk(srcSel == opt[1:0], "R7", "srcSel held after release", srcSel, opt[1:0]);
    chk(expQ.size() == 0, "R4", "pending events", expQ.size(), 0);
    porIn = 1'b1;
    #1;
    checkResetState("post");
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checkResetState("initial");
    runSeq(8'h50, 1'b0, 1'b0);   // stays on source 0
    runSeq(8'hA7, 1'b0, 1'b0);   // fastest source
    runSeq(8'h3D, 1'b0, 1'b1);   // option changed after capture
    runSeq(8'h62, 1'b1, 1'b0);   // aborted during phase 2
    runSeq(8'h62, 1'b0, 1'b0);   // full sequence after abort
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule